// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block holds a 128-bit one-time-programmable fuse array and serves two commands through a request/acknowledge interface. The first reads one 32-bit fuse word. The second burns one fuse bit, which takes a programmable number of cycles. An unburned fuse reads 1 and a burned fuse reads 0. Nothing can turn a 0 back into a 1.

Fuses 0 to 87 are user fuses. The low six of them act as write locks, each guarding one 16-bit slice of the array. Because the slice that holds the locks is guarded by lock 0, the lock fuses can freeze themselves. Fuses 88 to 127 hold identity values that are loaded at reset: an 8-bit manufacturer code and a 32-bit serial number. No command can change them. The four fuses 84 to 87 are exported continuously so that an external comparator can use them as a device-select value.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset every user fuse (0..87) reads 1. A successful burn turns the addressed fuse to 0. No later command ever returns a 0 fuse to 1.
- R2: A read (`op_i`=0) takes its word address from `addr_i[1:0]` and ignores all higher address bits. It returns `rdata_o` bit j = fuse[32*w+j]. `ack_o` pulses in the cycle after the request is accepted, with `status_o`=00 (ok).
- R3: For k in 0..5, when fuse k is 0 a burn of any fuse from 16k to 16k+15 is refused. The refusal gives `status_o`=01 (execution error) with `ack_o` in the cycle after acceptance, no busy period and no change to the array.
- R4: Burning fuse 0 freezes all eight lock fuses. Fuses 6 and 7 never block any burn.
- R5: A burn (`op_i`=1) whose 16-bit fuse number on `addr_i` exceeds 87 returns `status_o`=10 (parse error) and changes nothing. Fuses 88..95 read the manufacturer code and fuses 96..127 read the serial number from reset onward, and they never change.
- R6: `burn_time_i`=0x0000 selects the short burn of SHORT_CYC busy cycles. `burn_time_i`=0x8000 selects the long burn of LONG_CYC busy cycles. Any other value returns `status_o`=10 and nothing is burned.
- R7: An accepted valid burn holds `busy_o` high for exactly the selected number of cycles, starting in the cycle after acceptance. `ack_o` pulses with `status_o`=00 in the cycle after `busy_o` falls, and the burned fuse is visible from that cycle. Requests made while `busy_o` is high are ignored.
- R8: `sel_field_o` always equals fuses {87,86,85,84}, with fuse 87 as the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; loads fuse preset |
| req_i | input | 1 | Command request, accepted when not busy |
| op_i | input | 1 | 0 = read word, 1 = burn fuse |
| addr_i | input | 16 | Word address (read) or fuse number (burn) |
| burn_time_i | input | 16 | Burn duration select: 0x0000 short, 0x8000 long |
| ack_o | output | 1 | One-cycle command completion pulse |
| busy_o | output | 1 | High during a burn period |
| status_o | output | 2 | 00 ok, 01 execution error, 10 parse error |
| rdata_o | output | 32 | Read data, updated on a read acknowledge |
| sel_field_o | output | 4 | Fuses 87..84 for device selection |

## Verification
A corrupted fuse register shows up on the read port at the next read of its word. For fuses 84 to 87 it shows up on `sel_field_o` in the same cycle. A wrong lock decode shows up in the cycle after a burn request, as the wrong status or as a busy period that should not start. A wrong burn counter shows up as `busy_o` falling one cycle early or late against the model, which checks every cycle. An identity fuse overwritten by an out-of-range burn appears in the next read of words 2 or 3.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  typedef enum logic [1:0] {
    ST_OK        = 2'b00,
    ST_EXEC_ERR  = 2'b01,
    ST_PARSE_ERR = 2'b10
  } otp_status_e;

  localparam logic        OP_READ  = 1'b0;
  localparam logic        OP_BURN  = 1'b1;
  localparam logic [15:0] BT_SHORT = 16'h0000;
  localparam logic [15:0] BT_LONG  = 16'h8000;
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int          N_FUSE     = 128,
  parameter int          USER_FUSES = 88,
  parameter int          ID_W       = 8,
  parameter int          SN_W       = 32,
  parameter logic [7:0]  MFR_ID     = 8'hA7,
  parameter logic [31:0] SERIAL     = 32'h1234_5678,
  localparam int         FN_W       = $clog2(N_FUSE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              burn_en_i,
  input  logic [FN_W-1:0]   burn_idx_i,
  output logic [N_FUSE-1:0] fuse_o
);
  localparam logic [N_FUSE-1:0] PRESET =
    {SERIAL[SN_W-1:0], MFR_ID[ID_W-1:0], {USER_FUSES{1'b1}}};

  logic [N_FUSE-1:0] fuse_q;

  for (genvar i = 0; i < N_FUSE; i++) begin : g_bit
    if (i < USER_FUSES) begin : g_user
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fuse_q[i] <= PRESET[i];
        else if (burn_en_i && (burn_idx_i == FN_W'(i))) fuse_q[i] <= 1'b0;
      end
    end else begin : g_id
      // identity fuses: preset only, no write path
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fuse_q[i] <= PRESET[i];
      end
    end
  end

  assign fuse_o = fuse_q;

  AST_NEVER_UNBURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_q & ~$past(fuse_q)) == '0); // R1
  AST_BURN_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burn_en_i |-> (int'(burn_idx_i) < USER_FUSES)); // R5
endmodule

// File: rtl/otp_lock_check.sv
module otp_lock_check #(
  parameter int  N_LOCK     = 8,
  parameter int  N_LOCK_ACT = 6,
  parameter int  LOCK_SPAN  = 16,
  parameter int  FN_W       = 7,
  localparam int SPAN_W     = $clog2(LOCK_SPAN),
  localparam int IDX_W      = FN_W - SPAN_W
) (
  input  logic [N_LOCK-1:0] lock_bits_i,
  input  logic [FN_W-1:0]   fnum_i,
  output logic              locked_o
);
  logic [IDX_W-1:0]      slice_idx;
  logic [N_LOCK_ACT-1:0] hit;

  assign slice_idx = fnum_i[FN_W-1:SPAN_W];

  // only the first N_LOCK_ACT lock fuses guard a slice
  for (genvar k = 0; k < N_LOCK_ACT; k++) begin : g_lock
    assign hit[k] = (slice_idx == IDX_W'(k)) && !lock_bits_i[k];
  end

  assign locked_o = |hit;
endmodule

// File: rtl/otp_burn_timer.sv
module otp_burn_timer #(
  parameter int  SHORT_CYC = 4,
  parameter int  LONG_CYC  = 12,
  localparam int CW        = $clog2(LONG_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  output logic busy_o,
  output logic done_o
);
  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= long_i ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign busy_o = active_q;
  assign done_o = active_q && (cnt_q == '0);

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !active_q); // R7
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int          N_FUSE     = 128,
  parameter int          WORD_W     = 32,
  parameter int          USER_FUSES = 88,
  parameter int          N_LOCK     = 8,
  parameter int          N_LOCK_ACT = 6,
  parameter int          LOCK_SPAN  = 16,
  parameter int          SEL_LSB    = 84,
  parameter int          SEL_W      = 4,
  parameter int          SHORT_CYC  = 4,
  parameter int          LONG_CYC   = 12,
  parameter logic [7:0]  MFR_ID     = 8'hA7,
  parameter logic [31:0] SERIAL     = 32'h1234_5678
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              op_i,
  input  logic [15:0]       addr_i,
  input  logic [15:0]       burn_time_i,
  output logic              ack_o,
  output logic              busy_o,
  output logic [1:0]        status_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [SEL_W-1:0]  sel_field_o
);
  localparam int FN_W = $clog2(N_FUSE);
  localparam int WA_W = $clog2(N_FUSE / WORD_W);

  logic [N_FUSE-1:0] fuse;
  logic              accept, is_burn, range_err, time_err, parse_err, locked;
  logic              start, t_busy, t_done;
  logic [FN_W-1:0]   fnum, pend_idx_q;
  logic [WORD_W-1:0] word_sel;
  logic              ack_q;
  otp_status_e       status_q;
  logic [WORD_W-1:0] rdata_q;

  assign accept    = req_i && !t_busy;
  assign is_burn   = (op_i == OP_BURN);
  assign range_err = (addr_i > 16'(USER_FUSES - 1));
  assign time_err  = (burn_time_i != BT_SHORT) && (burn_time_i != BT_LONG);
  assign parse_err = range_err || time_err;
  assign fnum      = addr_i[FN_W-1:0];
  assign start     = accept && is_burn && !parse_err && !locked;
  assign word_sel  = fuse[int'(addr_i[WA_W-1:0]) * WORD_W +: WORD_W];

  otp_fuse_array #(
    .N_FUSE(N_FUSE), .USER_FUSES(USER_FUSES), .ID_W(8), .SN_W(32),
    .MFR_ID(MFR_ID), .SERIAL(SERIAL)
  ) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .burn_en_i(t_done), .burn_idx_i(pend_idx_q), .fuse_o(fuse)
  );

  otp_lock_check #(
    .N_LOCK(N_LOCK), .N_LOCK_ACT(N_LOCK_ACT), .LOCK_SPAN(LOCK_SPAN), .FN_W(FN_W)
  ) u_lock (
    .lock_bits_i(fuse[N_LOCK-1:0]), .fnum_i(fnum), .locked_o(locked)
  );

  otp_burn_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .long_i(burn_time_i == BT_LONG), .busy_o(t_busy), .done_o(t_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q      <= 1'b0;
      status_q   <= ST_OK;
      rdata_q    <= '0;
      pend_idx_q <= '0;
    end else begin
      ack_q <= 1'b0;
      if (t_done) begin
        ack_q    <= 1'b1;
        status_q <= ST_OK;
      end else if (accept) begin
        if (!is_burn) begin
          ack_q    <= 1'b1;
          status_q <= ST_OK;
          rdata_q  <= word_sel;
        end else if (parse_err) begin
          ack_q    <= 1'b1;
          status_q <= ST_PARSE_ERR;
        end else if (locked) begin
          ack_q    <= 1'b1;
          status_q <= ST_EXEC_ERR;
        end else begin
          pend_idx_q <= fnum;
        end
      end
    end
  end

  assign ack_o       = ack_q;
  assign busy_o      = t_busy;
  assign status_o    = status_q;
  assign rdata_o     = rdata_q;
  assign sel_field_o = fuse[SEL_LSB +: SEL_W];

  AST_BUSY_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ack_o); // R7
  AST_ERR_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && status_o != ST_OK) |-> (!busy_o && $stable(fuse))); // R3
  AST_RANGE_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_burn && range_err) |=> (ack_o && !busy_o && status_o == ST_PARSE_ERR)); // R5
  AST_LOCK_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_burn && !parse_err && locked) |=> (ack_o && !busy_o && status_o == ST_EXEC_ERR)); // R4
endmodule

// File: tb/tb_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module tb_otp_fuse_ctrl;
  localparam int          SHORT_N = 4;
  localparam int          LONG_N  = 12;
  localparam logic [7:0]  MFR     = 8'hA7;
  localparam logic [31:0] SN      = 32'h1234_5678;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, op = 0;
  logic [15:0] addr = 0, bt = 0;
  logic        ack, busy;
  logic [1:0]  status;
  logic [31:0] rdata;
  logic [3:0]  sel;

  int checks = 0, fails = 0, cycles = 0;
  bit model [128];
  bit exp_busy = 0, exp_ack = 0, cmp_on = 0;

  otp_fuse_ctrl #(.SHORT_CYC(SHORT_N), .LONG_CYC(LONG_N), .MFR_ID(MFR), .SERIAL(SN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .burn_time_i(bt), .ack_o(ack), .busy_o(busy), .status_o(status),
    .rdata_o(rdata), .sel_field_o(sel));

  always #2.5 clk = ~clk;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [3:0] es;
      es = {model[87], model[86], model[85], model[84]};
      check(busy == exp_busy, "R7 busy", 32'(busy), 32'(exp_busy));
      check(ack == exp_ack, "R7 ack", 32'(ack), 32'(exp_ack));
      check(sel == es, "R8 sel_field", 32'(sel), 32'(es));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] model_word(int w);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = model[32*w + j];
    return r;
  endfunction

  task automatic do_read(logic [15:0] a, string tag);
    logic [31:0] e;
    @(posedge clk); #1;
    req = 1; op = 0; addr = a;
    @(posedge clk); #1;
    req = 0; exp_ack = 1;
    e = model_word(int'(a[1:0]));
    @(negedge clk); #0.5;
    check(rdata == e, tag, rdata, e);
    check(status == 2'b00, {tag, " status"}, 32'(status), 0);
    @(posedge clk); #1;
    exp_ack = 0;
  endtask

  task automatic do_burn(logic [15:0] num, logic [15:0] t, string tag);
    logic [1:0] es;
    int n;
    if (num > 87 || (t != 16'h0000 && t != 16'h8000)) es = 2'b10;      // R5 / R6
    else if (num / 16 < 6 && model[num / 16] == 0) es = 2'b01;          // R3
    else es = 2'b00;
    n = (t == 16'h8000) ? LONG_N : SHORT_N;
    @(posedge clk); #1;
    req = 1; op = 1; addr = num; bt = t;
    @(posedge clk); #1;
    req = 0;
    if (es != 2'b00) begin
      exp_ack = 1;
    end else begin
      for (int i = 0; i < n; i++) begin
        exp_busy = 1;
        if (i == 1) begin req = 1; op = 0; addr = 0; end  // ignored while busy
        if (i == 2) req = 0;
        @(posedge clk); #1;
      end
      exp_busy = 0; exp_ack = 1;
      model[num] = 0;
    end
    @(negedge clk); #0.5;
    check(status == es, tag, 32'(status), 32'(es));
    @(posedge clk); #1;
    exp_ack = 0;
  endtask

  initial begin
    for (int i = 0; i < 88; i++) model[i] = 1;
    for (int i = 0; i < 8; i++) model[88 + i] = MFR[i];
    for (int i = 0; i < 32; i++) model[96 + i] = SN[i];
    #12; rst_n = 1;
    @(posedge clk); #1;
    cmp_on = 1;
    // R1 reset state, R5 identity preset, R2 reads
    do_read(16'h0000, "R1 reset word0");
    do_read(16'h0001, "R1 reset word1");
    do_read(16'h0002, "R5 mfr word2");
    do_read(16'h0003, "R5 serial word3");
    // R6 short burn, R2 high address bits ignored
    do_burn(16'd20, 16'h0000, "R6 short burn");
    do_read(16'hFFF0, "R2 high bits ignored");
    // R6 long burn, R8 select field
    do_burn(16'd85, 16'h8000, "R6 long burn");
    do_read(16'h0002, "R1 word2 after burn");
    // R5 out-of-range fuse numbers
    do_burn(16'd88, 16'h0000, "R5 fuse 88");
    do_burn(16'h0103, 16'h0000, "R5 fuse 259");
    do_burn(16'd127, 16'h8000, "R5 fuse 127");
    do_read(16'h0003, "R5 serial unchanged");
    // R6 bad burn time
    do_burn(16'd30, 16'h0001, "R6 bad time");
    do_burn(16'd30, 16'h8001, "R6 bad time2");
    do_read(16'h0000, "R6 no burn on bad time");
    // R3 lock bit 1 blocks fuses 16..31
    do_burn(16'd1, 16'h0000, "R3 burn lock1");
    do_burn(16'd17, 16'h0000, "R3 locked 17");
    do_burn(16'd31, 16'h8000, "R3 locked 31");
    do_burn(16'd32, 16'h0000, "R3 unlocked 32");
    do_read(16'h0000, "R3 word0 after lock");
    // R4 lock fuses 6/7 have no effect
    do_burn(16'd6, 16'h0000, "R4 burn lock6");
    do_burn(16'd7, 16'h0000, "R4 burn lock7");
    do_burn(16'd86, 16'h0000, "R4 fuse 86 ok");
    do_burn(16'd70, 16'h0000, "R4 fuse 70 ok");
    // R3 lock bit 5 blocks 80..87
    do_burn(16'd5, 16'h0000, "R3 burn lock5");
    do_burn(16'd84, 16'h0000, "R3 locked 84");
    // R4 lock 0 freezes lock fuses
    do_burn(16'd0, 16'h0000, "R4 burn lock0");
    do_burn(16'd2, 16'h0000, "R4 lock2 frozen");
    do_burn(16'd15, 16'h8000, "R4 fuse 15 frozen");
    do_read(16'h0000, "R4 word0 frozen");
    do_read(16'h0002, "R1 word2 final");
    do_read(16'h0001, "R1 word1 final");
    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule